// File: doc/BRIEF.md
# Multicore Performance Counter Control Unit

This block keeps a bank of event counters for a group of processor cores, one counter per event per core. Counting is governed by a shared enable register that any core can write through its own control-register write port. The new enable value does not reach every core at once. Each core holds a private copy of it behind a short chain of registers, so a change takes effect a fixed number of cycles after the write.

A second control register shuts the system down. A write to it from any core raises a halt output that stays high, and the block pulses a notification for the host for one cycle. From then on the counters are frozen. They remain readable through a host query port, which takes a core index and an event index and returns the 64-bit count one cycle later with a valid strobe.

Top module: `perf_ctl_hub`

## Requirements
- R1: After reset every counter reads zero, the enable register is off (events do not count), `halt`, `host_notify` and `host_rsp_valid` are low.
- R2: While core c's enable copy is on and the system is not halted, each cycle in which strobe bit c*NUM_EVENTS+e of `evt_strobe` is high adds one to counter (c, e). Otherwise that counter holds its value.
- R3: A write to address 0x801 sets the enable register to bit 0 of the write data (1 = counting on). Events sampled in the cycle of the write and in the two cycles after it still use the old enable. Events from the third cycle after the write onward use the new value.
- R4: When several cores write address 0x801 in the same cycle, the value from the lowest-numbered of those cores is the one kept.
- R5: A write of any data to address 0x800 by any core makes `halt` high from the next cycle onward, until reset. `host_notify` is high for exactly that first cycle. Events sampled in the same cycle as that write are still counted.
- R6: Once `halt` is high, no counter changes, whatever the strobes and register writes.
- R7: A query accepted with `host_req_valid` in one cycle yields `host_rsp_valid` high in the next cycle, with `host_rsp_data` holding the count as it stood before any increment in the query cycle. Queries keep working after halt.
- R8: Writes to any address other than 0x800 and 0x801 change neither the enable register nor the halt state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_en | input | NUM_CORES | Per-core register write strobe |
| csr_wr_addr | input | NUM_CORES*ADDR_W | Per-core write address, core c in bits [c*ADDR_W +: ADDR_W] |
| csr_wr_data | input | NUM_CORES*DATA_W | Per-core write data, core c in bits [c*DATA_W +: DATA_W] |
| evt_strobe | input | NUM_CORES*NUM_EVENTS | Per-core event pulses, bit c*NUM_EVENTS+e for core c, event e |
| host_req_valid | input | 1 | Host query request |
| host_req_core | input | CIDX_W | Core index of the query |
| host_req_evt | input | EIDX_W | Event index of the query |
| host_rsp_valid | output | 1 | Query response valid, one cycle after the request |
| host_rsp_data | output | CNT_W | Queried counter value |
| halt | output | 1 | System halted, sticky until reset |
| host_notify | output | 1 | One-cycle pulse when the halt begins |

## Verification
A wrong enable register or a stuck stage in a core's enable chain shows up as a counter that runs when it should hold, or holds when it should run. It becomes visible at the query port on the fourth sampled edge after the write that should have changed it. A corrupt halt state shows up at once on `halt` or `host_notify`, or as counters that still move after shutdown. A misplaced boundary in the three-cycle lag shows as a count that is off by exactly one in the lag test.

// File: rtl/perf_ctl_hub.sv
module perf_ctl_hub #(
  parameter int NUM_CORES  = 2,
  parameter int NUM_EVENTS = 4,
  parameter int CNT_W      = 64,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 64,
  parameter logic [ADDR_W-1:0] STATS_ADDR = 12'h801,
  parameter logic [ADDR_W-1:0] TERM_ADDR  = 12'h800,
  localparam int CIDX_W = (NUM_CORES  > 1) ? $clog2(NUM_CORES)  : 1,
  localparam int EIDX_W = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CORES-1:0]           csr_wr_en,
  input  logic [NUM_CORES*ADDR_W-1:0]    csr_wr_addr,
  input  logic [NUM_CORES*DATA_W-1:0]    csr_wr_data,
  input  logic [NUM_CORES*NUM_EVENTS-1:0] evt_strobe,
  input  logic                           host_req_valid,
  input  logic [CIDX_W-1:0]              host_req_core,
  input  logic [EIDX_W-1:0]              host_req_evt,
  output logic                           host_rsp_valid,
  output logic [CNT_W-1:0]               host_rsp_data,
  output logic                           halt,
  output logic                           host_notify
);

  localparam int LAG = 3;
  localparam logic [CIDX_W:0] NC_LIM = NUM_CORES[CIDX_W:0];
  localparam logic [EIDX_W:0] NE_LIM = NUM_EVENTS[EIDX_W:0];

  logic                 stats_q, stats_d;
  logic                 halt_q, notify_q;
  logic [NUM_CORES-1:0] hit_stats, hit_term, core_en;
  logic [LAG-1:0]       en_pipe [NUM_CORES];
  logic [CNT_W-1:0]     cnt [NUM_CORES][NUM_EVENTS];
  logic                 rsp_v_q;
  logic [CNT_W-1:0]     rsp_d_q;
  logic [1:0]           age_q;
  logic                 data_unused;

  assign data_unused = ^csr_wr_data;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_dec
    assign hit_stats[c] = !halt_q && csr_wr_en[c] &&
                          (csr_wr_addr[c*ADDR_W +: ADDR_W] == STATS_ADDR);
    assign hit_term[c]  = !halt_q && csr_wr_en[c] &&
                          (csr_wr_addr[c*ADDR_W +: ADDR_W] == TERM_ADDR);
  end

  always_comb begin
    stats_d = stats_q;
    for (int c = NUM_CORES - 1; c >= 0; c--)
      if (hit_stats[c]) stats_d = csr_wr_data[c*DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stats_q  <= 1'b0;
      halt_q   <= 1'b0;
      notify_q <= 1'b0;
      age_q    <= 2'd0;
    end else begin
      stats_q  <= stats_d;
      halt_q   <= halt_q | (|hit_term);
      notify_q <= |hit_term;
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    always_ff @(posedge clk) begin
      if (!rst_n) en_pipe[c] <= '0;
      else        en_pipe[c] <= {en_pipe[c][LAG-2:0], stats_d};
    end
    assign core_en[c] = en_pipe[c][LAG-1];

    // R3: each core's enable copy trails the shared register by the fixed lag
    a_r3_enable_lag: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 2'd2) |-> (core_en[c] == $past(stats_q, 2)));

    for (genvar e = 0; e < NUM_EVENTS; e++) begin : g_evt
      always_ff @(posedge clk) begin
        if (!rst_n)
          cnt[c][e] <= '0;
        else if (!halt_q && core_en[c] && evt_strobe[c*NUM_EVENTS+e])
          cnt[c][e] <= cnt[c][e] + 1'b1;
      end

      // R6: counters frozen once halted
      a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q |=> $stable(cnt[c][e]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      rsp_v_q <= host_req_valid;
      if (host_req_valid) begin
        if (({1'b0, host_req_core} < NC_LIM) && ({1'b0, host_req_evt} < NE_LIM))
          rsp_d_q <= cnt[host_req_core][host_req_evt];
        else
          rsp_d_q <= '0;
      end
    end
  end

  assign host_rsp_valid = rsp_v_q;
  assign host_rsp_data  = rsp_d_q;
  assign halt           = halt_q;
  assign host_notify    = notify_q;

  // R4: core 0 always has precedence on the enable register
  a_r4_core0_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stats[0] |=> (stats_q == $past(csr_wr_data[0])));

  // R5: halt is sticky and the notification is a single pulse inside it
  a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);
  a_r5_notify_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_notify |=> !host_notify);
  a_r5_notify_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
    host_notify |-> halt);

  // R7: response strobe follows the request by one cycle
  a_r7_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    host_req_valid |=> host_rsp_valid);
  a_r7_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !host_req_valid |=> !host_rsp_valid);

endmodule

// File: tb/perf_ctl_hub_tb_top.sv
module perf_ctl_hub_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int NE = 4;
  localparam int AW = 12;
  localparam int DW = 64;
  localparam int NROWS = 10;
  localparam logic [NC*NE-1:0] STIM [NROWS] = '{
    8'h01, 8'h81, 8'hFF, 8'h10, 8'h22, 8'h0C, 8'hF0, 8'h03, 8'h80, 8'h55};

  logic clk = 1'b0;
  logic rst_n;
  logic [NC-1:0]    csr_wr_en;
  logic [NC*AW-1:0] csr_wr_addr;
  logic [NC*DW-1:0] csr_wr_data;
  logic [NC*NE-1:0] evt_strobe;
  logic             host_req_valid;
  logic [0:0]       host_req_core;
  logic [1:0]       host_req_evt;
  logic             host_rsp_valid;
  logic [63:0]      host_rsp_data;
  logic             halt;
  logic             host_notify;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [63:0] exp_cnt [NC][NE];

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_ctl_hub dut_i (
    .clk(clk), .rst_n(rst_n),
    .csr_wr_en(csr_wr_en), .csr_wr_addr(csr_wr_addr), .csr_wr_data(csr_wr_data),
    .evt_strobe(evt_strobe),
    .host_req_valid(host_req_valid), .host_req_core(host_req_core),
    .host_req_evt(host_req_evt),
    .host_rsp_valid(host_rsp_valid), .host_rsp_data(host_rsp_data),
    .halt(halt), .host_notify(host_notify));

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_in();
    csr_wr_en = '0; csr_wr_addr = '0; csr_wr_data = '0;
    evt_strobe = '0; host_req_valid = 1'b0; host_req_core = '0; host_req_evt = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_wr(input int core, input logic [AW-1:0] addr, input logic [DW-1:0] data);
    csr_wr_en[core] = 1'b1;
    csr_wr_addr[core*AW +: AW] = addr;
    csr_wr_data[core*DW +: DW] = data;
  endtask

  task automatic rd(input int c, input int e, input string req);
    host_req_valid = 1'b1;
    host_req_core = c[0:0];
    host_req_evt = e[1:0];
    tick();
    host_req_valid = 1'b0;
    chk({63'd0, host_rsp_valid}, 64'd1, req);
    chk(host_rsp_data, exp_cnt[c][e], req);
  endtask

  task automatic count_all(input logic [NC*NE-1:0] m);
    for (int b = 0; b < NC*NE; b++)
      if (m[b]) exp_cnt[b/NE][b%NE] = exp_cnt[b/NE][b%NE] + 64'd1;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++)
      for (int e = 0; e < NE; e++) exp_cnt[c][e] = 64'd0;
    clr_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1: reset state
    chk({63'd0, halt}, 64'd0, "R1 halt");
    chk({63'd0, host_notify}, 64'd0, "R1 notify");
    chk({63'd0, host_rsp_valid}, 64'd0, "R1 rsp_valid");
    rd(1, 3, "R1 counter zero");
    evt_strobe = '1;
    repeat (3) tick();
    evt_strobe = '0;
    rd(0, 0, "R1 disabled after reset");

    // R2: enable, then walk the stimulus table
    set_wr(0, 12'h801, 64'd1);
    tick();
    clr_in();
    repeat (3) tick();
    for (int i = 0; i < NROWS; i++) begin
      evt_strobe = STIM[i];
      count_all(STIM[i]);
      tick();
    end
    evt_strobe = '0;
    for (int c = 0; c < NC; c++)
      for (int e = 0; e < NE; e++) rd(c, e, "R2 table counts");

    // R3: disable lag, three more events counted
    set_wr(0, 12'h801, 64'd0);
    evt_strobe = 8'h01;
    tick();
    clr_in();
    evt_strobe = 8'h01;
    repeat (4) tick();
    evt_strobe = '0;
    exp_cnt[0][0] = exp_cnt[0][0] + 64'd3;
    rd(0, 0, "R3 disable lag");

    // R3: enable lag, two of five events counted
    set_wr(0, 12'h801, 64'd1);
    evt_strobe = 8'h01;
    tick();
    clr_in();
    evt_strobe = 8'h01;
    repeat (4) tick();
    evt_strobe = '0;
    exp_cnt[0][0] = exp_cnt[0][0] + 64'd2;
    rd(0, 0, "R3 enable lag");

    // R4: simultaneous writes, core 0 wins (disable)
    set_wr(0, 12'h801, 64'd0);
    set_wr(1, 12'h801, 64'd1);
    tick();
    clr_in();
    repeat (3) tick();
    evt_strobe = 8'h20;
    repeat (2) tick();
    evt_strobe = '0;
    rd(1, 1, "R4 core0 disable wins");

    // R4: simultaneous writes, core 0 wins (enable)
    set_wr(0, 12'h801, 64'd1);
    set_wr(1, 12'h801, 64'd0);
    tick();
    clr_in();
    repeat (3) tick();
    evt_strobe = 8'h20;
    repeat (2) tick();
    evt_strobe = '0;
    exp_cnt[1][1] = exp_cnt[1][1] + 64'd2;
    rd(1, 1, "R4 core0 enable wins");

    // R8: write to an unrelated address leaves counting on and no halt
    set_wr(1, 12'h802, 64'd0);
    tick();
    clr_in();
    chk({63'd0, halt}, 64'd0, "R8 no halt");
    repeat (3) tick();
    evt_strobe = 8'h02;
    tick();
    evt_strobe = '0;
    exp_cnt[0][1] = exp_cnt[0][1] + 64'd1;
    rd(0, 1, "R8 enable unchanged");

    // R7: query and increment in the same cycle return the old value
    evt_strobe = 8'h02;
    rd(0, 1, "R7 old value on same-cycle event");
    evt_strobe = '0;
    exp_cnt[0][1] = exp_cnt[0][1] + 64'd1;
    rd(0, 1, "R7 updated value");

    // R5: terminate from core 1 with arbitrary data, same-cycle event counted
    set_wr(1, 12'h800, 64'hDEAD);
    evt_strobe = 8'h40;
    tick();
    clr_in();
    exp_cnt[1][2] = exp_cnt[1][2] + 64'd1;
    chk({63'd0, halt}, 64'd1, "R5 halt raised");
    chk({63'd0, host_notify}, 64'd1, "R5 notify pulse");
    tick();
    chk({63'd0, host_notify}, 64'd0, "R5 notify one cycle");
    chk({63'd0, halt}, 64'd1, "R5 halt sticky");

    // R6: after halt nothing moves, writes have no effect
    set_wr(0, 12'h801, 64'd1);
    set_wr(1, 12'h800, 64'd5);
    evt_strobe = '1;
    repeat (3) tick();
    clr_in();
    evt_strobe = '1;
    repeat (3) tick();
    clr_in();
    chk({63'd0, host_notify}, 64'd0, "R6 no second notify");
    for (int c = 0; c < NC; c++)
      for (int e = 0; e < NE; e++) rd(c, e, "R6 frozen, R7 readable after halt");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule